// File: doc/BRIEF.md
# Interrupt Priority and In-Service Tracker

This block keeps the per-vector interrupt state of a local interrupt controller for 256 vectors. There are three bitmaps: one for requests waiting to be taken, one for vectors the core is servicing, and one for the trigger kind of each vector. The block receives new vector requests, task-priority updates, acknowledge strobes from the core and end-of-interrupt writes. It offers the core the single most urgent vector that the current processor priority allows.

Processor priority combines the task priority with the priority class of the most urgent vector in service. A vector in the reserved range below 16 is never handed to the core. The block flags the error and offers the configured error vector in its place. When a level-triggered vector completes, the block sends a one-cycle broadcast that carries the vector number, so that the sources of such interrupts can re-arm.

Top module: `vec_prio_tracker`

## Requirements
- R1: While rst_ni is low, all three bitmaps, the task priority, the processor priority, the error status and the interrupt-present output are cleared.
- R2: A request for vector v whose pending bit is clear sets pending bit v on the next edge. If level_i is 1, it also sets trigger bit v, where a trigger bit of 1 means level-triggered.
- R3: A request for a vector whose pending bit is already set is discarded, and its trigger bit stays unchanged.
- R4: The vector offered is the highest-numbered pending vector. irq_valid_o and irq_vector_o reflect the bitmaps one cycle after they change.
- R5: Processor priority is formed from t = task[7:4] and c = bits [7:4] of the highest in-service vector, with c = 0 when nothing is in service. If t >= c it equals the task priority; otherwise it is {c, 4'h0}. ppr_o shows it one cycle after the state it is derived from.
- R6: A pending vector is offered only when it is greater than or equal to the processor priority. The task priority holds the 8 bits of the last write.
- R7: An acknowledge of the offered vector sets its in-service bit and clears its pending bit. irq_valid_o is low on the cycle after the acknowledge.
- R8: An end-of-interrupt write clears the highest in-service bit. With nothing in service it changes nothing and sends no broadcast.
- R9: If the vector cleared by an end-of-interrupt has its trigger bit set, the trigger bit clears. eoi_bcast_o is high for exactly one cycle, with eoi_bcast_vec_o equal to that vector.
- R10: If the vector to be offered is below 16, the block offers err_vector_i instead, sets pending bit err_vector_i and sets error-status bit 5 (value 0x20). The bit stays set until esr_clr_i is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | New vector request strobe |
| acc_vector_i | input | 8 | Requested vector |
| acc_level_i | input | 1 | Request is level-triggered |
| tpr_wr_i | input | 1 | Task-priority write strobe |
| tpr_data_i | input | 8 | Task-priority write value |
| ack_i | input | 1 | Core takes the offered vector |
| eoi_wr_i | input | 1 | End-of-interrupt write strobe |
| err_vector_i | input | 8 | Vector used for the reserved-range error |
| esr_clr_i | input | 1 | Clears the error status |
| irq_valid_o | output | 1 | A vector is offered |
| irq_vector_o | output | 8 | Offered vector |
| ppr_o | output | 8 | Processor priority |
| tpr_o | output | 8 | Task priority |
| esr_o | output | 8 | Error status, bit 5 = reserved vector seen |
| irr_o | output | 256 | Pending bitmap |
| isr_o | output | 256 | In-service bitmap |
| tmr_o | output | 256 | Trigger bitmap, 1 = level |
| eoi_bcast_o | output | 1 | Level end-of-interrupt broadcast pulse |
| eoi_bcast_vec_o | output | 8 | Vector of the broadcast |

## Verification
The bench builds the block with a 16-bit search group, which splits the 256-vector encoders into 16 groups. Every group boundary and every group-selection path is therefore exercised. With this configuration, a full sweep of all 240 non-reserved vectors is affordable. Each vector passes through request, offer, acknowledge and end-of-interrupt, and its expected priority class and broadcast are computed arithmetically from the vector number. Directed sequences add masking by task priority and by in-service class, duplicate requests, an empty end-of-interrupt and the reserved-vector substitution.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int NUM_VEC    = 256;
  localparam int VEC_W      = $clog2(NUM_VEC);
  localparam int CLS_W      = 4;
  localparam int RSVD_LIMIT = 16;
  localparam int ERR_BIT    = 5;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/vpt_prio_enc.sv
module vpt_prio_enc #(
  parameter int N       = 256,
  parameter int GROUP_W = 32
) (
  input  logic [N-1:0]         bits_i,
  output logic                 found_o,
  output logic [$clog2(N)-1:0] idx_o
);
  localparam int NG = N / GROUP_W;
  localparam int GW = (GROUP_W > 1) ? $clog2(GROUP_W) : 1;
  localparam int IW = $clog2(N);

  function automatic logic [GW-1:0] hi_in_group(input logic [GROUP_W-1:0] b);
    logic [GW-1:0] r;
    r = '0;
    for (int i = 0; i < GROUP_W; i++) if (b[i]) r = GW'(i);
    return r;
  endfunction

  logic [NG-1:0]    grp_any;
  logic [NG*GW-1:0] grp_idx;

  for (genvar g = 0; g < NG; g++) begin : gen_grp
    assign grp_any[g]           = |bits_i[g*GROUP_W +: GROUP_W];
    assign grp_idx[g*GW +: GW]  = hi_in_group(bits_i[g*GROUP_W +: GROUP_W]);
  end

  // highest non-empty group wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int g = 0; g < NG; g++) begin
      if (grp_any[g]) begin
        found_o = 1'b1;
        idx_o   = IW'(g * GROUP_W + int'(grp_idx[g*GW +: GW]));
      end
    end
  end
endmodule

// File: rtl/vpt_ppr_calc.sv
module vpt_ppr_calc
  import vpt_pkg::*;
(
  input  vec_t tpr_i,
  input  logic isr_found_i,
  input  vec_t isr_hi_i,
  output vec_t ppr_o
);
  logic [CLS_W-1:0] t_cls, s_cls;

  always_comb begin
    t_cls = tpr_i[VEC_W-1 -: CLS_W];
    s_cls = isr_found_i ? isr_hi_i[VEC_W-1 -: CLS_W] : '0;
    if (t_cls >= s_cls) ppr_o = tpr_i;
    else                ppr_o = {s_cls, {(VEC_W-CLS_W){1'b0}}};
  end
endmodule

// File: rtl/vpt_bitmaps.sv
module vpt_bitmaps
  import vpt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  vec_t               acc_vec_i,
  input  logic               acc_level_i,
  input  logic               ack_i,
  input  vec_t               ack_vec_i,
  input  logic               eoi_i,
  input  vec_t               eoi_vec_i,
  input  logic               err_set_i,
  input  vec_t               err_vec_i,
  output logic [NUM_VEC-1:0] irr_o,
  output logic [NUM_VEC-1:0] isr_o,
  output logic [NUM_VEC-1:0] tmr_o,
  output logic               bcast_o,
  output vec_t               bcast_vec_o
);
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
  logic               bcast_q;
  vec_t               bcast_vec_q;

  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (ack_i) irr_d[ack_vec_i] = 1'b0;
    if (err_set_i) irr_d[err_vec_i] = 1'b1;
    if (eoi_i) begin
      isr_d[eoi_vec_i] = 1'b0;
      tmr_d[eoi_vec_i] = 1'b0;
    end
    // duplicate request is dropped entirely
    if (acc_valid_i && !irr_q[acc_vec_i]) begin
      irr_d[acc_vec_i] = 1'b1;
      if (acc_level_i) tmr_d[acc_vec_i] = 1'b1;
    end
    if (ack_i) isr_d[ack_vec_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q       <= '0;
      isr_q       <= '0;
      tmr_q       <= '0;
      bcast_q     <= 1'b0;
      bcast_vec_q <= '0;
    end else begin
      irr_q       <= irr_d;
      isr_q       <= isr_d;
      tmr_q       <= tmr_d;
      bcast_q     <= eoi_i && tmr_q[eoi_vec_i];
      bcast_vec_q <= eoi_vec_i;
    end
  end

  assign irr_o       = irr_q;
  assign isr_o       = isr_q;
  assign tmr_o       = tmr_q;
  assign bcast_o     = bcast_q;
  assign bcast_vec_o = bcast_vec_q;

  // R2
  fresh_accept_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !irr_q[acc_vec_i]) |=> irr_q[$past(acc_vec_i)]);

  // R9
  bcast_needs_eoi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_q |-> ($past(eoi_i) && !tmr_q[bcast_vec_q]));
endmodule

// File: rtl/vec_prio_tracker.sv
module vec_prio_tracker
  import vpt_pkg::*;
#(
  parameter int GROUP_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  logic [7:0]         acc_vector_i,
  input  logic               acc_level_i,
  input  logic               tpr_wr_i,
  input  logic [7:0]         tpr_data_i,
  input  logic               ack_i,
  input  logic               eoi_wr_i,
  input  logic [7:0]         err_vector_i,
  input  logic               esr_clr_i,
  output logic               irq_valid_o,
  output logic [7:0]         irq_vector_o,
  output logic [7:0]         ppr_o,
  output logic [7:0]         tpr_o,
  output logic [7:0]         esr_o,
  output logic [255:0]       irr_o,
  output logic [255:0]       isr_o,
  output logic [255:0]       tmr_o,
  output logic               eoi_bcast_o,
  output logic [7:0]         eoi_bcast_vec_o
);
  logic [NUM_VEC-1:0] irr_w, isr_w, tmr_w;
  logic irr_found, isr_found;
  vec_t irr_hi, isr_hi, ppr_now;
  vec_t tpr_q, ppr_q, irq_vec_q;
  logic irq_valid_q, esr_bit_q;
  logic hit, rsvd, err_set, ack_do, eoi_do;

  vpt_prio_enc #(.N(NUM_VEC), .GROUP_W(GROUP_W)) u_irr_enc (
    .bits_i(irr_w), .found_o(irr_found), .idx_o(irr_hi));

  vpt_prio_enc #(.N(NUM_VEC), .GROUP_W(GROUP_W)) u_isr_enc (
    .bits_i(isr_w), .found_o(isr_found), .idx_o(isr_hi));

  vpt_ppr_calc u_ppr (
    .tpr_i(tpr_q), .isr_found_i(isr_found), .isr_hi_i(isr_hi), .ppr_o(ppr_now));

  assign hit     = irr_found && (irr_hi >= ppr_now);
  assign rsvd    = hit && (irr_hi < VEC_W'(RSVD_LIMIT));
  assign err_set = rsvd && !ack_i;
  assign ack_do  = ack_i && irq_valid_q;
  assign eoi_do  = eoi_wr_i && isr_found;

  vpt_bitmaps u_maps (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid_i),
    .acc_vec_i   (acc_vector_i),
    .acc_level_i (acc_level_i),
    .ack_i       (ack_do),
    .ack_vec_i   (irq_vec_q),
    .eoi_i       (eoi_do),
    .eoi_vec_i   (isr_hi),
    .err_set_i   (err_set),
    .err_vec_i   (err_vector_i),
    .irr_o       (irr_w),
    .isr_o       (isr_w),
    .tmr_o       (tmr_w),
    .bcast_o     (eoi_bcast_o),
    .bcast_vec_o (eoi_bcast_vec_o)
  );

  // offer is dropped on the acknowledge cycle so a stale vector is never taken twice
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpr_q       <= '0;
      ppr_q       <= '0;
      irq_valid_q <= 1'b0;
      irq_vec_q   <= '0;
      esr_bit_q   <= 1'b0;
    end else begin
      if (tpr_wr_i) tpr_q <= tpr_data_i;
      ppr_q       <= ppr_now;
      irq_valid_q <= hit && !ack_i;
      irq_vec_q   <= rsvd ? err_vector_i : irr_hi;
      esr_bit_q   <= err_set || (esr_bit_q && !esr_clr_i);
    end
  end

  always_comb begin
    esr_o          = '0;
    esr_o[ERR_BIT] = esr_bit_q;
  end

  assign irq_valid_o  = irq_valid_q;
  assign irq_vector_o = irq_vec_q;
  assign ppr_o        = ppr_q;
  assign tpr_o        = tpr_q;
  assign irr_o        = irr_w;
  assign isr_o        = isr_w;
  assign tmr_o        = tmr_w;

  // R5
  ppr_low_from_tpr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ppr_q[3:0] != 4'h0) |-> (ppr_q == $past(tpr_q)));

  // R7
  ack_drops_offer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_valid_q);

  // R8
  empty_eoi_noop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr_i && (isr_w == '0) && !ack_do) |=> $stable(isr_w));

  // R10
  rsvd_substitute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(esr_bit_q) |-> (irq_valid_q && (irq_vec_q == $past(err_vector_i))));
endmodule

// File: tb/vec_prio_tracker_tb.sv
module vec_prio_tracker_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic acc_valid = 1'b0, acc_level = 1'b0, tpr_wr = 1'b0, ack = 1'b0;
  logic eoi = 1'b0, esr_clr = 1'b0;
  logic [7:0] acc_vec = '0, tpr_data = '0, err_vec = 8'hE0;
  logic irq_valid, bcast;
  logic [7:0] irq_vec, ppr, tpr, esr, bcast_vec;
  logic [255:0] irr, isr, tmr;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vec_prio_tracker #(.GROUP_W(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .acc_valid_i(acc_valid), .acc_vector_i(acc_vec), .acc_level_i(acc_level),
    .tpr_wr_i(tpr_wr), .tpr_data_i(tpr_data), .ack_i(ack), .eoi_wr_i(eoi),
    .err_vector_i(err_vec), .esr_clr_i(esr_clr),
    .irq_valid_o(irq_valid), .irq_vector_o(irq_vec), .ppr_o(ppr), .tpr_o(tpr),
    .esr_o(esr), .irr_o(irr), .isr_o(isr), .tmr_o(tmr),
    .eoi_bcast_o(bcast), .eoi_bcast_vec_o(bcast_vec));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic accept(input int v, input bit lvl);
    acc_valid = 1'b1; acc_vec = 8'(v); acc_level = lvl;
    tick(1);
    acc_valid = 1'b0; acc_level = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1; tick(1); eoi = 1'b0;
  endtask

  task automatic set_tpr(input int v);
    tpr_wr = 1'b1; tpr_data = 8'(v); tick(1); tpr_wr = 1'b0;
  endtask

  task automatic check_reset(input string tag);
    chk({"R1 irr ", tag}, int'(irr != '0), 0);
    chk({"R1 isr ", tag}, int'(isr != '0), 0);
    chk({"R1 tmr ", tag}, int'(tmr != '0), 0);
    chk({"R1 valid ", tag}, int'(irq_valid), 0);
    chk({"R1 tpr ", tag}, int'(tpr), 0);
    chk({"R1 ppr ", tag}, int'(ppr), 0);
    chk({"R1 esr ", tag}, int'(esr), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    tick(3);
    check_reset("at start");
    rst_ni = 1'b1;
    tick(2);

    // full sweep over non-reserved vectors
    for (int v = 16; v < 256; v++) begin
      bit lvl = v[0];
      accept(v, lvl);
      chk("R2 irr set", int'(irr[v]), 1);
      chk("R2 tmr kind", int'(tmr[v]), int'(lvl));
      tick(1);
      chk("R4 valid", int'(irq_valid), 1);
      chk("R4 vector", int'(irq_vec), v);
      do_ack();
      chk("R7 isr set", int'(isr[v]), 1);
      chk("R7 irr clear", int'(irr[v]), 0);
      chk("R7 valid drop", int'(irq_valid), 0);
      tick(1);
      chk("R5 ppr class", int'(ppr), v & 8'hF0);
      do_eoi();
      chk("R9 bcast", int'(bcast), int'(lvl));
      if (lvl) chk("R9 bcast vec", int'(bcast_vec), v);
      chk("R8 isr clear", int'(isr[v]), 0);
      chk("R9 tmr clear", int'(tmr[v]), 0);
      tick(1);
      chk("R9 one pulse", int'(bcast), 0);
      chk("R8 ppr back", int'(ppr), 0);
    end

    // ordering and in-service masking
    accept(8'h30, 0); accept(8'h90, 0); accept(8'h60, 0);
    tick(1);
    chk("R4 highest first", int'(irq_vec), 8'h90);
    do_ack(); tick(1);
    chk("R6 masked by isr class", int'(irq_valid), 0);
    do_eoi(); tick(1);
    chk("R4 next highest", int'(irq_vec), 8'h60);
    chk("R4 next valid", int'(irq_valid), 1);
    do_ack(); do_eoi(); tick(1);
    chk("R4 last", int'(irq_vec), 8'h30);
    do_ack(); do_eoi(); tick(1);

    // task priority masking
    set_tpr(8'h57); tick(1);
    chk("R6 tpr held", int'(tpr), 8'h57);
    chk("R5 ppr from tpr", int'(ppr), 8'h57);
    accept(8'h56, 0); tick(1);
    chk("R6 below ppr", int'(irq_valid), 0);
    accept(8'h57, 0); tick(1);
    chk("R6 equal ppr", int'(irq_vec), 8'h57);
    chk("R6 equal valid", int'(irq_valid), 1);
    do_ack(); tick(1);
    chk("R5 t>=c", int'(ppr), 8'h57);
    set_tpr(8'h35); tick(1);
    chk("R5 t<c", int'(ppr), 8'h50);
    chk("R6 now allowed", int'(irq_vec), 8'h56);
    chk("R6 now valid", int'(irq_valid), 1);
    do_ack(); do_eoi(); do_eoi(); set_tpr(0); tick(2);
    chk("R8 both cleared", int'(isr != '0), 0);

    // duplicate request
    accept(8'h40, 0); accept(8'h40, 1);
    chk("R3 dup keeps tmr", int'(tmr[8'h40]), 0);
    chk("R3 irr still set", int'(irr[8'h40]), 1);
    tick(1); do_ack(); do_eoi();
    chk("R3 no bcast", int'(bcast), 0);
    tick(1);

    // empty end-of-interrupt
    do_eoi();
    chk("R8 empty no bcast", int'(bcast), 0);
    chk("R8 empty isr", int'(isr != '0), 0);
    tick(1);
    chk("R8 empty ppr", int'(ppr), 0);

    // reserved vector substitution
    accept(8'h05, 0); tick(1);
    chk("R10 vector", int'(irq_vec), 8'hE0);
    chk("R10 valid", int'(irq_valid), 1);
    chk("R10 esr", int'(esr), 8'h20);
    chk("R10 err irr", int'(irr[8'hE0]), 1);
    do_ack(); tick(1);
    chk("R10 esr sticky", int'(esr), 8'h20);
    esr_clr = 1'b1; tick(1); esr_clr = 1'b0;
    chk("R10 esr clear", int'(esr), 0);

    // reset from dirty state
    rst_ni = 1'b0; tick(1);
    check_reset("dirty");
    rst_ni = 1'b1; tick(1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule